// File: doc/BRIEF.md
# Prefetch Event Address Filter

This block sits beside a level-1 data cache and watches what the cache does. It sees three kinds of event: a demand load request, the data that returns after a demand miss, and data that returns for a prefetch. It decides, event by event, whether a prefetch engine downstream should see it. An event is forwarded when its virtual address falls inside one of a few programmable array windows, or when its cache line equals one of a few individually tagged lines.

Each forwarded event becomes one observation record. The record holds the event kind, the index of the array window that matched, a flag that says the event got through only on a tagged line, the address and one data word. These two fields let the downstream handler be chosen per array and per event kind. Observations go to an external queue. The filter never stalls the cache. When the queue reports full, a matching event is discarded and a saturating drop counter is incremented. Windows and tagged lines are set through a small register write port.

Top module: `pf_event_filter`

## Requirements
- R1: After reset `obs_valid` is 0 and `drop_count` is 0. Every window has base = limit = 0, so it matches nothing, and every tagged line is invalid.
- R2: An event matches window i when base_i <= addr < limit_i, with the comparison unsigned. A matching event with `q_full` low appears on the observation outputs exactly one clock later. It carries its kind, its address, its data and the window index, with `obs_by_tag` = 0.
- R3: When several windows match, the lowest-numbered window is reported.
- R4: A valid tagged line matches when address bits [63:6] are equal, which means 64-byte lines. An event that matches only a tagged line is forwarded with `obs_by_tag` = 1 and `obs_range` = 0. If a window also matches, the window result is reported and `obs_by_tag` = 0.
- R5: Event kind codes are 0 for a load request, 1 for miss-fill data and 2 for prefetch-fill data. They are copied unchanged to `obs_kind`. Kind 3 is ignored: it produces no observation and no drop. An event that matches no window and no tagged line produces nothing.
- R6: When `q_full` is high, a matching event produces no observation and `drop_count` rises by 1 in the same clock. Non-matching events leave `drop_count` unchanged.
- R7: `drop_count` saturates at its all-ones value.
- R8: The configuration port uses `cfg_sel` to pick the action. 0 writes a window base. 1 writes a window limit. 2 loads the line of `cfg_wdata` into a tagged slot and marks it valid. 3 invalidates a tagged slot. `cfg_idx` picks the window or slot. After an invalidate, that line no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_valid | input | 1 | Snooped cache event present |
| snp_kind | input | 2 | Event kind code |
| snp_addr | input | 64 | Virtual address of the event |
| snp_data | input | 64 | Data word or tag that goes with the event |
| q_full | input | 1 | Observation queue cannot accept |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration action |
| cfg_idx | input | 2 | Window or tagged slot index |
| cfg_wdata | input | 64 | Configuration value |
| obs_valid | output | 1 | Observation record valid this cycle |
| obs_kind | output | 2 | Kind of the forwarded event |
| obs_range | output | 2 | Matching window index |
| obs_by_tag | output | 1 | Forwarded only because of a tagged line |
| obs_addr | output | 64 | Address of the forwarded event |
| obs_data | output | 64 | Data of the forwarded event |
| drop_count | output | DROP_W | Saturating count of discarded matches |

## Verification
The bench uses the default four windows, four tagged slots and 64-byte lines. With these it can test overlapping windows, both window edges, tagged lines that sit inside and outside a window, and all kind codes. It shrinks DROP_W to 4, so the drop counter reaches saturation after fifteen discarded events and the hold at all-ones can be observed within a short run.

// File: rtl/pf_filt_pkg.sv
package pf_filt_pkg;
   typedef enum logic [1:0] {
      EV_LOAD      = 2'd0,
      EV_MISS_FILL = 2'd1,
      EV_PF_FILL   = 2'd2,
      EV_NONE      = 2'd3
   } ev_kind_e;

   typedef enum logic [1:0] {
      CFG_BASE    = 2'd0,
      CFG_LIMIT   = 2'd1,
      CFG_TAG_SET = 2'd2,
      CFG_TAG_CLR = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/pf_range_match.sv
module pf_range_match #(
   parameter int N  = 4,
   parameter int AW = 64,
   parameter int IW = 2
) (
   input  logic [AW-1:0]        addr,
   input  logic [N-1:0][AW-1:0] base,
   input  logic [N-1:0][AW-1:0] limit,
   output logic                 hit,
   output logic [IW-1:0]        idx
);
   logic [N-1:0] m;

   for (genvar i = 0; i < N; i++) begin : g_win
      assign m[i] = (addr >= base[i]) && (addr < limit[i]);
   end

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (m[i]) begin
            hit = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/pf_tag_match.sv
module pf_tag_match #(
   parameter int N  = 4,
   parameter int LW = 58
) (
   input  logic [LW-1:0]        line,
   input  logic [N-1:0][LW-1:0] tags,
   input  logic [N-1:0]         valid,
   output logic                 hit
);
   logic [N-1:0] m;

   for (genvar i = 0; i < N; i++) begin : g_slot
      assign m[i] = valid[i] && (line == tags[i]);
   end

   assign hit = |m;
endmodule

// File: rtl/pf_event_filter.sv
module pf_event_filter #(
   parameter int ADDR_W     = 64,
   parameter int DATA_W     = 64,
   parameter int NUM_RANGES = 4,
   parameter int NUM_TAGS   = 4,
   parameter int LINE_BYTES = 64,
   parameter int DROP_W     = 16,
   localparam int RID_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1,
   localparam int NMAX  = (NUM_RANGES > NUM_TAGS) ? NUM_RANGES : NUM_TAGS,
   localparam int IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic [1:0]        snp_kind,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [DATA_W-1:0] snp_data,
   input  logic              q_full,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic              obs_valid,
   output logic [1:0]        obs_kind,
   output logic [RID_W-1:0]  obs_range,
   output logic              obs_by_tag,
   output logic [ADDR_W-1:0] obs_addr,
   output logic [DATA_W-1:0] obs_data,
   output logic [DROP_W-1:0] drop_count
);
   import pf_filt_pkg::*;

   localparam int LB = $clog2(LINE_BYTES);
   localparam int LW = ADDR_W - LB;

   if (NUM_RANGES < 1 || NUM_TAGS < 1) begin : g_bad_count
      $error("pf_event_filter: need at least one window and one tag slot");
   end
   if (LINE_BYTES < 2 || (1 << LB) != LINE_BYTES) begin : g_bad_line
      $error("pf_event_filter: LINE_BYTES must be a power of two");
   end
   if (DROP_W < 1) begin : g_bad_drop
      $error("pf_event_filter: DROP_W must be positive");
   end

   logic [NUM_RANGES-1:0][ADDR_W-1:0] win_base, win_limit;
   logic [NUM_TAGS-1:0][LW-1:0]       tag_line;
   logic [NUM_TAGS-1:0]               tag_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_base  <= '0;
         win_limit <= '0;
         tag_line  <= '0;
         tag_vld   <= '0;
      end else if (cfg_we) begin
         case (cfg_sel_e'(cfg_sel))
            CFG_BASE:
               if (32'(cfg_idx) < NUM_RANGES) win_base[cfg_idx] <= cfg_wdata;
            CFG_LIMIT:
               if (32'(cfg_idx) < NUM_RANGES) win_limit[cfg_idx] <= cfg_wdata;
            CFG_TAG_SET:
               if (32'(cfg_idx) < NUM_TAGS) begin
                  tag_line[cfg_idx] <= cfg_wdata[ADDR_W-1:LB];
                  tag_vld[cfg_idx]  <= 1'b1;
               end
            default:
               if (32'(cfg_idx) < NUM_TAGS) tag_vld[cfg_idx] <= 1'b0;
         endcase
      end
   end

   logic             r_hit, t_hit;
   logic [RID_W-1:0] r_idx;

   pf_range_match #(.N(NUM_RANGES), .AW(ADDR_W), .IW(RID_W)) u_range (
      .addr(snp_addr), .base(win_base), .limit(win_limit),
      .hit(r_hit), .idx(r_idx)
   );

   pf_tag_match #(.N(NUM_TAGS), .LW(LW)) u_tag (
      .line(snp_addr[ADDR_W-1:LB]), .tags(tag_line), .valid(tag_vld),
      .hit(t_hit)
   );

   logic accept;
   assign accept = snp_valid && (ev_kind_e'(snp_kind) != EV_NONE) && (r_hit || t_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obs_valid  <= 1'b0;
         obs_kind   <= '0;
         obs_range  <= '0;
         obs_by_tag <= 1'b0;
         obs_addr   <= '0;
         obs_data   <= '0;
         drop_count <= '0;
      end else begin
         obs_valid <= accept && !q_full;
         if (accept && !q_full) begin
            obs_kind   <= snp_kind;
            obs_range  <= r_hit ? r_idx : '0;
            obs_by_tag <= !r_hit;
            obs_addr   <= snp_addr;
            obs_data   <= snp_data;
         end
         if (accept && q_full && (drop_count != '1)) begin
            drop_count <= drop_count + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pf_event_filter_chk.sv
module pf_event_filter_chk #(
   parameter int ADDR_W = 64,
   parameter int RID_W  = 2,
   parameter int DROP_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              snp_valid,
   input logic [1:0]        snp_kind,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              q_full,
   input logic              obs_valid,
   input logic [1:0]        obs_kind,
   input logic [RID_W-1:0]  obs_range,
   input logic              obs_by_tag,
   input logic [ADDR_W-1:0] obs_addr,
   input logic [DROP_W-1:0] drop_count
);
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!obs_valid && drop_count == '0));

   a_r2_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !q_full) |=>
         (!obs_valid || (obs_addr == $past(snp_addr) && obs_kind == $past(snp_kind))));

   a_r4_tag_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (obs_valid && obs_by_tag) |-> (obs_range == '0));

   a_r5_kind3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_kind == 2'd3) |=> (!obs_valid && $stable(drop_count)));

   a_r6_full_no_out: assert property (@(posedge clk) disable iff (!rst_n)
      (!snp_valid || q_full) |=> !obs_valid);

   a_r6_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      !(snp_valid && q_full) |=> $stable(drop_count));

   a_r7_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + 1'b1));
endmodule

bind pf_event_filter pf_event_filter_chk #(
   .ADDR_W(ADDR_W), .RID_W(RID_W), .DROP_W(DROP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_kind(snp_kind),
   .snp_addr(snp_addr), .q_full(q_full), .obs_valid(obs_valid),
   .obs_kind(obs_kind), .obs_range(obs_range), .obs_by_tag(obs_by_tag),
   .obs_addr(obs_addr), .drop_count(drop_count)
);

// File: tb/pf_event_filter_tb.sv
module pf_event_filter_tb_top;
   localparam int DW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        snp_valid = 1'b0;
   logic [1:0]  snp_kind = '0;
   logic [63:0] snp_addr = '0, snp_data = '0;
   logic        q_full = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0, cfg_idx = '0;
   logic [63:0] cfg_wdata = '0;
   logic        obs_valid, obs_by_tag;
   logic [1:0]  obs_kind, obs_range;
   logic [63:0] obs_addr, obs_data;
   logic [DW-1:0] drop_count;

   int total = 0, bad = 0;

   always #5 clk = ~clk;

   pf_event_filter #(.DROP_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_kind(snp_kind),
      .snp_addr(snp_addr), .snp_data(snp_data), .q_full(q_full),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .obs_valid(obs_valid), .obs_kind(obs_kind), .obs_range(obs_range),
      .obs_by_tag(obs_by_tag), .obs_addr(obs_addr), .obs_data(obs_data),
      .drop_count(drop_count)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic [63:0] addr;
      logic        e_vld;
      logic [1:0]  e_rng;
      logic        e_tag;
   } vec_t;

   // windows: 0=[1000,2000) 1=[1800,3000) 2=[8000,8100) 3=[10000,10040); tags 0x5000, 0x1000
   localparam vec_t VEC [12] = '{
      '{2'd0, 64'h1000,  1'b1, 2'd0, 1'b0},  // R2 base inclusive (tag also hits: R4)
      '{2'd1, 64'h1FFF,  1'b1, 2'd0, 1'b0},  // R2
      '{2'd2, 64'h2000,  1'b1, 2'd1, 1'b0},  // R2 limit exclusive
      '{2'd0, 64'h1800,  1'b1, 2'd0, 1'b0},  // R3 overlap
      '{2'd0, 64'h2FFF,  1'b1, 2'd1, 1'b0},  // R2
      '{2'd1, 64'h3000,  1'b0, 2'd0, 1'b0},  // R5 no match
      '{2'd2, 64'h503F,  1'b1, 2'd0, 1'b1},  // R4 tag line
      '{2'd0, 64'h5040,  1'b0, 2'd0, 1'b0},  // R4 next line
      '{2'd3, 64'h1000,  1'b0, 2'd0, 1'b0},  // R5 kind 3
      '{2'd0, 64'h80FF,  1'b1, 2'd2, 1'b0},  // R2
      '{2'd1, 64'h1003F, 1'b1, 2'd3, 1'b0},  // R5 kind passthrough
      '{2'd0, 64'h4FFF,  1'b0, 2'd0, 1'b0}   // R4 previous line
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [1:0] idx, input logic [63:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input logic [1:0] kind, input logic [63:0] addr, input logic full);
      @(negedge clk);
      snp_valid = 1'b1; snp_kind = kind; snp_addr = addr; snp_data = ~addr; q_full = full;
      @(negedge clk);
      snp_valid = 1'b0; q_full = 1'b0;
   endtask

   initial begin
      #1_000_000;
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] d0;
      repeat (3) @(negedge clk);
      chk(obs_valid == 1'b0, "R1 obs_valid", 64'(obs_valid), 0);
      chk(drop_count == '0, "R1 drop_count", 64'(drop_count), 0);
      rst_n = 1'b1;
      send(2'd0, 64'h0, 1'b0);
      chk(obs_valid == 1'b0, "R1 empty windows", 64'(obs_valid), 0);

      cfg(2'd0, 2'd0, 64'h1000);  cfg(2'd1, 2'd0, 64'h2000);
      cfg(2'd0, 2'd1, 64'h1800);  cfg(2'd1, 2'd1, 64'h3000);
      cfg(2'd0, 2'd2, 64'h8000);  cfg(2'd1, 2'd2, 64'h8100);
      cfg(2'd0, 2'd3, 64'h10000); cfg(2'd1, 2'd3, 64'h10040);
      cfg(2'd2, 2'd0, 64'h5000);  cfg(2'd2, 2'd1, 64'h1010);  // R8 set tags

      for (int i = 0; i < 12; i++) begin
         send(VEC[i].kind, VEC[i].addr, 1'b0);
         chk(obs_valid == VEC[i].e_vld, "R2/R5 valid", 64'(obs_valid), 64'(VEC[i].e_vld));
         if (VEC[i].e_vld) begin
            chk(obs_range == VEC[i].e_rng, "R3 range", 64'(obs_range), 64'(VEC[i].e_rng));
            chk(obs_by_tag == VEC[i].e_tag, "R4 by_tag", 64'(obs_by_tag), 64'(VEC[i].e_tag));
            chk(obs_kind == VEC[i].kind, "R5 kind", 64'(obs_kind), 64'(VEC[i].kind));
            chk(obs_addr == VEC[i].addr && obs_data == ~VEC[i].addr, "R2 addr/data",
                obs_addr, VEC[i].addr);
         end
      end
      chk(drop_count == '0, "R6 no drops yet", 64'(drop_count), 0);

      // R6 full drops a matching event
      send(2'd0, 64'h1234, 1'b1);
      chk(obs_valid == 1'b0, "R6 no obs when full", 64'(obs_valid), 0);
      chk(drop_count == DW'(1), "R6 drop incr", 64'(drop_count), 1);
      send(2'd0, 64'h3000, 1'b1);
      chk(drop_count == DW'(1), "R6 nonmatch not counted", 64'(drop_count), 1);
      send(2'd3, 64'h1234, 1'b1);
      chk(drop_count == DW'(1), "R5 kind3 not counted", 64'(drop_count), 1);

      // R7 saturation
      for (int i = 0; i < 20; i++) send(2'd1, 64'h8000, 1'b1);
      chk(drop_count == '1, "R7 saturate", 64'(drop_count), 64'(DW'('1)));
      d0 = drop_count;
      send(2'd1, 64'h8000, 1'b1);
      chk(drop_count == d0, "R7 hold", 64'(drop_count), 64'(d0));

      // R8 tag invalidate
      cfg(2'd3, 2'd0, 64'h0);
      send(2'd2, 64'h5000, 1'b0);
      chk(obs_valid == 1'b0, "R8 cleared tag", 64'(obs_valid), 0);
      send(2'd2, 64'h2000, 1'b0);
      chk(obs_valid == 1'b1 && obs_range == 2'd1, "R8 windows intact", 64'(obs_range), 1);

      // R1 reset again clears counter
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk(drop_count == '0 && obs_valid == 1'b0, "R1 re-reset", 64'(drop_count), 0);
      rst_n = 1'b1;
      send(2'd0, 64'h1000, 1'b0);
      chk(obs_valid == 1'b0, "R1 windows cleared", 64'(obs_valid), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule